// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block decides when a CPU may sleep and what wakes it. Two sleep depths are entered by one-cycle request strobes from the instruction sequencer. The deep level gates the main oscillator, so every clock stops, the timer clock included. The light level gates only the CPU clock and keeps the oscillator and the timer clock running. In each level a different set of interrupt request lines counts as a wake source.

The five interrupt request lines are external pin, keyboard, serial, timer and multifunction timer. They are sampled as levels on the rising clock edge and are assumed to be synchronous to the clock already. When a qualifying request is seen, the block returns to normal running on the next edge. It restores all clock enables and raises a single-cycle wake pulse so the sequencer can start interrupt processing. An asynchronous active-low reset returns the block to normal running from any state.

Top module: `lowPowerWake`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in the running state: oscEn, cpuClkEn and timClkEn are 1 and wakePulse is 0. This holds even when reset arrives during either sleep level.
- R2: A stopReq sampled while running makes oscEn, cpuClkEn and timClkEn all 0 from the next rising edge.
- R3: A waitReq sampled while running makes cpuClkEn 0 from the next rising edge. oscEn and timClkEn stay 1 for as long as the light sleep lasts.
- R4: When stopReq and waitReq are sampled together while running, the deep sleep is entered (all three enables 0).
- R5: A stopReq or waitReq sampled during either sleep level has no effect. The enables keep their sleep values.
- R6: In deep sleep only irqExt (irqVec bit 0) or irqKey (bit 1) wakes the block. irqSci (bit 2), irqTim (bit 3) and irqMft (bit 4) are ignored and leave all enables at 0.
- R7: In light sleep any of the five request lines wakes the block.
- R8: On the edge that samples a qualifying wake request, the block returns to running. All three enables are 1 and wakePulse is 1 for exactly that one cycle.
- R9: Interrupt requests sampled while running never raise wakePulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Deep-sleep request strobe |
| waitReq | input | 1 | Light-sleep request strobe |
| irqExt | input | 1 | External pin interrupt request |
| irqKey | input | 1 | Keyboard interrupt request |
| irqSci | input | 1 | Serial interrupt request |
| irqTim | input | 1 | Timer interrupt request |
| irqMft | input | 1 | Multifunction-timer interrupt request |
| oscEn | output | 1 | Main oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| timClkEn | output | 1 | Timer clock enable |
| wakePulse | output | 1 | One-cycle wake indication to the sequencer |

## Verification
Two pairs of events can fall in the same cycle: a sleep request with interrupt activity, and a wake with a fresh sleep request. In the cycle right after a wake pulse, the block is running again and will accept a new stopReq or waitReq. In deep sleep, serial, timer and multifunction-timer requests may arrive together with a sleep strobe. The bench provokes both cases with directed sequences and with seeded random stimulus that raises requests and interrupts together. It judges every cycle against a bench-side model of the mode, the masks and the enables.

// File: rtl/lpwPkg.sv
package lpwPkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_STOP = 2'd1,
    PM_WAIT = 2'd2
  } pwrMode_t;

  typedef struct packed {
    logic enterStop;
    logic enterWait;
    logic wakeUp;
  } ctrlStrobe_t;
endpackage

// File: rtl/lpwDatapath.sv
module lpwDatapath
  import lpwPkg::*;
#(
  parameter int unsigned NUM_SRC = 5,
  parameter logic [NUM_SRC-1:0] STOP_WAKE_MASK = 5'b00011,
  parameter logic [NUM_SRC-1:0] WAIT_WAKE_MASK = 5'b11111
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqVec,
  input  ctrlStrobe_t        strb,
  output logic               stopWakeHit,
  output logic               waitWakeHit,
  output logic               oscEn,
  output logic               cpuClkEn,
  output logic               timClkEn,
  output logic               wakePulse
);
  logic [NUM_SRC-1:0] stopQual;
  logic [NUM_SRC-1:0] waitQual;

  // per-source qualification for each sleep level
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
    if (STOP_WAKE_MASK[i]) begin : g_stopOn
      assign stopQual[i] = irqVec[i];
    end else begin : g_stopOff
      assign stopQual[i] = 1'b0;
    end
    if (WAIT_WAKE_MASK[i]) begin : g_waitOn
      assign waitQual[i] = irqVec[i];
    end else begin : g_waitOff
      assign waitQual[i] = 1'b0;
    end
  end

  assign stopWakeHit = |stopQual;
  assign waitWakeHit = |waitQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscEn     <= 1'b1;
      cpuClkEn  <= 1'b1;
      timClkEn  <= 1'b1;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= strb.wakeUp;
      if (strb.enterStop) begin
        oscEn    <= 1'b0;
        cpuClkEn <= 1'b0;
        timClkEn <= 1'b0;
      end else if (strb.enterWait) begin
        cpuClkEn <= 1'b0;
      end else if (strb.wakeUp) begin
        oscEn    <= 1'b1;
        cpuClkEn <= 1'b1;
        timClkEn <= 1'b1;
      end
    end
  end

  // R2: deep entry gates every domain
  a_r2_stop_gates_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterStop |=> (!oscEn && !cpuClkEn && !timClkEn));
  // R3: light entry keeps oscillator and timer
  a_r3_wait_keeps_timer: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterWait |=> (oscEn && !cpuClkEn && timClkEn));
  // R8: wake restores all enables with a pulse
  a_r8_wake_restores: assert property (@(posedge clk) disable iff (!rstN)
    strb.wakeUp |=> (oscEn && cpuClkEn && timClkEn && wakePulse));
  // R8: the pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);
endmodule

// File: rtl/lpwCtrl.sv
module lpwCtrl
  import lpwPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReq,
  input  logic        waitReq,
  input  logic        stopWakeHit,
  input  logic        waitWakeHit,
  output ctrlStrobe_t strb,
  output pwrMode_t    mode
);
  pwrMode_t modeNext;

  always_comb begin
    strb     = '0;
    modeNext = mode;
    unique case (mode)
      PM_RUN: begin
        if (stopReq) begin
          strb.enterStop = 1'b1;
          modeNext       = PM_STOP;
        end else if (waitReq) begin
          strb.enterWait = 1'b1;
          modeNext       = PM_WAIT;
        end
      end
      PM_STOP: begin
        if (stopWakeHit) begin
          strb.wakeUp = 1'b1;
          modeNext    = PM_RUN;
        end
      end
      PM_WAIT: begin
        if (waitWakeHit) begin
          strb.wakeUp = 1'b1;
          modeNext    = PM_RUN;
        end
      end
      default: modeNext = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= PM_RUN;
    else       mode <= modeNext;
  end

  // R4: stop request wins when both strobes arrive
  a_r4_stop_priority: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_RUN && stopReq && waitReq) |=> (mode == PM_STOP));
  // R5, R6: deep sleep held without a qualifying source
  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_STOP && !stopWakeHit) |=> (mode == PM_STOP));
  // R5: light sleep held without a qualifying source
  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_WAIT && !waitWakeHit) |=> (mode == PM_WAIT));
  // R8: at most one strobe per cycle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enterStop, strb.enterWait, strb.wakeUp}));
endmodule

// File: rtl/lowPowerWake.sv
module lowPowerWake
  import lpwPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic stopReq,
  input  logic waitReq,
  input  logic irqExt,
  input  logic irqKey,
  input  logic irqSci,
  input  logic irqTim,
  input  logic irqMft,
  output logic oscEn,
  output logic cpuClkEn,
  output logic timClkEn,
  output logic wakePulse
);
  localparam int unsigned NUM_SRC = 5;

  logic [NUM_SRC-1:0] irqVec;
  ctrlStrobe_t        strb;
  pwrMode_t           mode;
  logic               stopWakeHit;
  logic               waitWakeHit;

  assign irqVec = {irqMft, irqTim, irqSci, irqKey, irqExt};

  lpwCtrl uCtrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .waitReq(waitReq),
    .stopWakeHit(stopWakeHit), .waitWakeHit(waitWakeHit),
    .strb(strb), .mode(mode)
  );

  lpwDatapath #(
    .NUM_SRC(NUM_SRC),
    .STOP_WAKE_MASK(5'b00011),
    .WAIT_WAKE_MASK(5'b11111)
  ) uDp (
    .clk(clk), .rstN(rstN), .irqVec(irqVec), .strb(strb),
    .stopWakeHit(stopWakeHit), .waitWakeHit(waitWakeHit),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .timClkEn(timClkEn),
    .wakePulse(wakePulse)
  );

  // R6: deep sleep keeps oscillator and timer off
  a_r6_stop_clocks_off: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_STOP) |-> (!oscEn && !timClkEn && !cpuClkEn));
  // R3: light sleep keeps timer running
  a_r3_wait_timer_on: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_WAIT) |-> (oscEn && timClkEn && !cpuClkEn));
  // R9: no pulse from running to running
  a_r9_no_run_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_RUN && $past(mode) == PM_RUN) |-> !wakePulse);
  // R1: running state has all enables on
  a_r1_run_enables: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_RUN) |-> (oscEn && cpuClkEn && timClkEn));
endmodule

// File: tb/tb_lowPowerWake.sv
`timescale 1ns/1ps
module tb_lowPowerWake;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, waitReq = 1'b0;
  logic irqExt = 1'b0, irqKey = 1'b0, irqSci = 1'b0, irqTim = 1'b0, irqMft = 1'b0;
  logic oscEn, cpuClkEn, timClkEn, wakePulse;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;
  int mSt = 0;      // 0 run, 1 deep, 2 light
  bit mWake = 1'b0;

  always #5 clk = ~clk;

  lowPowerWake dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .waitReq(waitReq),
    .irqExt(irqExt), .irqKey(irqKey), .irqSci(irqSci), .irqTim(irqTim),
    .irqMft(irqMft), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .timClkEn(timClkEn), .wakePulse(wakePulse)
  );

  function automatic logic [3:0] expOut(int st, bit wk);
    case (st)
      1:       return 4'b0000;
      2:       return 4'b1010;
      default: return {3'b111, wk};
    endcase
  endfunction

  function automatic string tagFor(int st, bit s, bit w, logic [4:0] irq);
    if (st == 0) return s ? (w ? "R4" : "R2") : (w ? "R3" : "R9");
    if (st == 1) return (|irq[1:0]) ? "R8" : ((|irq[4:2]) ? "R6" : ((s | w) ? "R5" : "R6"));
    return (|irq) ? "R7" : ((s | w) ? "R5" : "R3");
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s {osc,cpu,tim,wake} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // inputs applied at negedge, sampled at posedge, checked at following negedge
  task automatic step(bit s, bit w, logic [4:0] irq);
    string tag;
    tag = tagFor(mSt, s, w, irq);
    stopReq = s; waitReq = w;
    {irqMft, irqTim, irqSci, irqKey, irqExt} = irq;
    @(posedge clk);
    mWake = 1'b0;
    if (mSt == 0) begin
      if (s) mSt = 1; else if (w) mSt = 2;
    end else if (mSt == 1) begin
      if (|irq[1:0]) begin mSt = 0; mWake = 1'b1; end
    end else begin
      if (|irq) begin mSt = 0; mWake = 1'b1; end
    end
    @(negedge clk);
    check(tag, {oscEn, cpuClkEn, timClkEn, wakePulse}, expOut(mSt, mWake));
  endtask

  task automatic midReset();
    rstN = 1'b0;
    #2;
    mSt = 0; mWake = 1'b0;
    check("R1", {oscEn, cpuClkEn, timClkEn, wakePulse}, 4'b1110);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failCount++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a2b));
    @(negedge clk);
    check("R1", {oscEn, cpuClkEn, timClkEn, wakePulse}, 4'b1110);
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 5'b00000);                // R1 idle after reset
    step(0, 0, 5'b11111);                // R9 irq while running
    step(1, 0, 5'b00000);                // R2 enter deep
    step(0, 0, 5'b00100);                // R6 serial ignored
    step(0, 0, 5'b01000);                // R6 timer ignored
    step(0, 1, 5'b10000);                // R6/R5 mft plus wait ignored
    step(0, 0, 5'b11100);                // R6 all three ignored
    step(0, 0, 5'b00001);                // R8 ext wake
    step(0, 0, 5'b00000);                // R8 pulse ends
    step(0, 1, 5'b00000);                // R3 enter light
    step(1, 0, 5'b00000);                // R5 stop ignored in light
    step(0, 0, 5'b01000);                // R7 timer wakes light
    step(1, 1, 5'b00000);                // R4 both, stop wins (right after wake)
    step(0, 0, 5'b00010);                // R8 key wakes deep
    step(0, 1, 5'b00000);                // R3 wake then immediate wait
    step(0, 0, 5'b10000);                // R7 mft wakes light
    step(0, 1, 5'b00000);
    step(0, 0, 5'b00100);                // R7 serial wakes light
    step(1, 0, 5'b00000);
    midReset();                          // R1 reset from deep
    step(0, 1, 5'b00000);
    midReset();                          // R1 reset from light
    step(0, 0, 5'b00000);
    for (int i = 0; i < 3000; i++) begin
      bit s, w;
      logic [4:0] irq;
      s = ($urandom % 5) == 0;
      w = ($urandom % 4) == 0;
      for (int b = 0; b < 5; b++) irq[b] = ($urandom % 9) == 0;
      step(s, w, irq);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule